// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two component predictors side by side and lets a table of choice counters decide which one to trust for each lookup. The first component keeps a short outcome history for each branch address and uses that history to select a 2-bit counter. The second component uses one history register of the most recent resolved outcomes, across all branches, to select a counter from its own table. The chooser table is indexed by that same global history. Each chooser counter leans toward whichever component has been right more often in that history context.

A lookup is purely combinational. The caller presents the word-aligned branch address bits. In the same cycle it gets the final prediction, both component predictions and the two history values that were used as table indices. The caller keeps those values with the branch. When the branch resolves, it returns them on the update port together with the real outcome. All tables and histories are written at the next clock edge. Only resolved branches advance the histories.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, every lookup returns local history 0 and global history 0. Every component prediction is not-taken and the final prediction is not-taken. All direction counters start at 1, the chooser counters start at 1, and all histories start at zero.
- R2: `lkpPc` (10 bits) selects one of 1024 local history entries, and `lkpLocalHist` returns that entry. A valid update at address `updPc` shifts the outcome into bit 0 of that entry (1 = taken) and drops the oldest of its 10 bits. Other entries do not change.
- R3: The local prediction is the upper bit of the local counter that the 10-bit local history selects.
- R4: Every valid update shifts the outcome into bit 0 of the 12-bit global history (1 = taken) and drops bit 11. `lkpGlobalHist` returns the register.
- R5: The global prediction is the upper bit of the global counter that the global history selects.
- R6: Each 2-bit counter adds one on a taken outcome and subtracts one on a not-taken outcome. It holds at 3 and at 0. It predicts taken when its value is 2 or 3.
- R7: When the chooser counter selected by the global history is 2 or 3, `predTaken` equals the global prediction. Otherwise it equals the local prediction.
- R8: On a valid update, the chooser counter changes only if `updLocalPred` and `updGlobalPred` differ. It adds one when the global prediction matched the outcome and subtracts one when the local prediction matched.
- R9: An update trains the local counter at `updLocalHist`, and the global and chooser counters at `updGlobalHist`. It does this even when the current histories have moved on since the lookup.
- R10: A lookup in the same cycle as an update to the same entries returns the values from before the update.
- R11: While `updValid` is low, no table or history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkpPc | input | 10 | Word-aligned branch address bits used for the lookup |
| predTaken | output | 1 | Final direction prediction |
| predLocal | output | 1 | Local component prediction |
| predGlobal | output | 1 | Global component prediction |
| lkpLocalHist | output | 10 | Local history read for this lookup |
| lkpGlobalHist | output | 12 | Global history used for this lookup |
| updValid | input | 1 | A resolved branch is presented for training |
| updPc | input | 10 | Address bits of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updLocalPred | input | 1 | Local prediction saved at lookup time |
| updGlobalPred | input | 1 | Global prediction saved at lookup time |
| updLocalHist | input | 10 | Local history saved at lookup time |
| updGlobalHist | input | 12 | Global history saved at lookup time |

## Verification
A lookup and an update can happen in the same cycle and touch the same history entry and counters. The bench drives both on one edge, with the lookup address equal to the update address and the saved indices equal to the current histories. In that cycle the outputs must still show the old histories and counters. After the edge they must show the shifted values. Training with saved indices that differ from the live global history exercises the other kind of overlap. In that case training must reach the entry that was used for the prediction, not the one the current history points to.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;

  typedef struct packed {
    logic histWe;    // shift outcome into both histories
    logic ctrWe;     // train local and global direction counters
    logic chooseWe;  // train the chooser counter
    logic chooseUp;  // chooser moves toward global when set
    logic outcome;   // resolved direction
  } tp_strobe_t;

  function automatic ctr_t ctrNext(input ctr_t c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/tourney_ctrl.sv
module tourney_ctrl
  import tourney_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updLocalPred,
  input  logic       updGlobalPred,
  input  logic       localPred,
  input  logic       globalPred,
  input  logic       choiceGlobal,
  output tp_strobe_t strb,
  output logic       predTaken
);

  always_comb begin
    strb.histWe   = updValid;
    strb.ctrWe    = updValid;
    strb.chooseWe = updValid && (updLocalPred != updGlobalPred);
    strb.chooseUp = (updGlobalPred == updTaken);
    strb.outcome  = updTaken;
  end

  assign predTaken = choiceGlobal ? globalPred : localPred;

  // R7: when both components agree the selection cannot matter
  p_agree_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (localPred == globalPred) |-> (predTaken == localPred));

endmodule

// File: rtl/tourney_datapath.sv
module tourney_datapath
  import tourney_pkg::*;
#(
  parameter int LHT_ENTRIES = 1024,
  parameter int LHIST_W     = 10,
  parameter int GHIST_W     = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  tp_strobe_t                     strb,
  input  logic [$clog2(LHT_ENTRIES)-1:0] lkpPc,
  input  logic [$clog2(LHT_ENTRIES)-1:0] updPc,
  input  logic [LHIST_W-1:0]             updLocalHist,
  input  logic [GHIST_W-1:0]             updGlobalHist,
  output logic [LHIST_W-1:0]             lkpLocalHist,
  output logic [GHIST_W-1:0]             lkpGlobalHist,
  output logic                           localPred,
  output logic                           globalPred,
  output logic                           choiceGlobal
);

  localparam int LPT_ENTRIES = 1 << LHIST_W;
  localparam int GPT_ENTRIES = 1 << GHIST_W;

  logic [LHIST_W-1:0] lht [LHT_ENTRIES];
  ctr_t               lpt [LPT_ENTRIES];
  ctr_t               gpt [GPT_ENTRIES];
  ctr_t               cht [GPT_ENTRIES];
  logic [GHIST_W-1:0] ghr;

  // Lookup: combinational reads see the state before this cycle's writes
  assign lkpLocalHist  = lht[lkpPc];
  assign lkpGlobalHist = ghr;
  assign localPred     = lpt[lkpLocalHist][1];
  assign globalPred    = gpt[ghr][1];
  assign choiceGlobal  = cht[ghr][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LHT_ENTRIES; i++) lht[i] <= '0;
      for (int i = 0; i < LPT_ENTRIES; i++) lpt[i] <= CTR_INIT;
      for (int i = 0; i < GPT_ENTRIES; i++) begin
        gpt[i] <= CTR_INIT;
        cht[i] <= CTR_INIT;
      end
      ghr <= '0;
    end else begin
      if (strb.histWe) begin
        lht[updPc] <= {lht[updPc][LHIST_W-2:0], strb.outcome};
        ghr        <= {ghr[GHIST_W-2:0], strb.outcome};
      end
      if (strb.ctrWe) begin
        lpt[updLocalHist]  <= ctrNext(lpt[updLocalHist], strb.outcome);
        gpt[updGlobalHist] <= ctrNext(gpt[updGlobalHist], strb.outcome);
      end
      if (strb.chooseWe)
        cht[updGlobalHist] <= ctrNext(cht[updGlobalHist], strb.chooseUp);
    end
  end

  // R4: older history bits move up by one place on each update
  p_ghr_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.histWe |=> (ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0])));

  // R11: without an update the global history holds
  p_ghr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.histWe |=> $stable(ghr));

  // R6: a full counter stays full on another taken outcome
  p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ctrWe && strb.outcome && lpt[updLocalHist] == 2'd3)
    |=> (lpt[$past(updLocalHist)] == 2'd3));

  // R6: an empty counter stays empty on another not-taken outcome
  p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ctrWe && !strb.outcome && gpt[updGlobalHist] == 2'd0)
    |=> (gpt[$past(updGlobalHist)] == 2'd0));

  // R8: with the chooser strobe off the trained chooser entry holds
  p_choose_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ctrWe && !strb.chooseWe)
    |=> (cht[$past(updGlobalHist)] == $past(cht[updGlobalHist])));

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tourney_pkg::*;
#(
  parameter int LHT_ENTRIES = 1024,
  parameter int LHIST_W     = 10,
  parameter int GHIST_W     = 12,
  localparam int PC_W       = $clog2(LHT_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    lkpPc,
  output logic               predTaken,
  output logic               predLocal,
  output logic               predGlobal,
  output logic [LHIST_W-1:0] lkpLocalHist,
  output logic [GHIST_W-1:0] lkpGlobalHist,
  input  logic               updValid,
  input  logic [PC_W-1:0]    updPc,
  input  logic               updTaken,
  input  logic               updLocalPred,
  input  logic               updGlobalPred,
  input  logic [LHIST_W-1:0] updLocalHist,
  input  logic [GHIST_W-1:0] updGlobalHist
);

  tp_strobe_t strb;
  logic       choiceGlobal;

  tourney_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .updValid     (updValid),
    .updTaken     (updTaken),
    .updLocalPred (updLocalPred),
    .updGlobalPred(updGlobalPred),
    .localPred    (predLocal),
    .globalPred   (predGlobal),
    .choiceGlobal (choiceGlobal),
    .strb         (strb),
    .predTaken    (predTaken)
  );

  tourney_datapath #(
    .LHT_ENTRIES(LHT_ENTRIES),
    .LHIST_W    (LHIST_W),
    .GHIST_W    (GHIST_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .lkpPc        (lkpPc),
    .updPc        (updPc),
    .updLocalHist (updLocalHist),
    .updGlobalHist(updGlobalHist),
    .lkpLocalHist (lkpLocalHist),
    .lkpGlobalHist(lkpGlobalHist),
    .localPred    (predLocal),
    .globalPred   (predGlobal),
    .choiceGlobal (choiceGlobal)
  );

endmodule

// File: tb/tourney_predictor_bench.sv
module tourney_predictor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  lkpPc = '0;
  logic        predTaken, predLocal, predGlobal;
  logic [9:0]  lkpLocalHist;
  logic [11:0] lkpGlobalHist;
  logic        updValid = 1'b0;
  logic [9:0]  updPc = '0;
  logic        updTaken = 1'b0;
  logic        updLocalPred = 1'b0;
  logic        updGlobalPred = 1'b0;
  logic [9:0]  updLocalHist = '0;
  logic [11:0] updGlobalHist = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_predictor u_tourney_predictor (
    .clk(clk), .rst_n(rst_n), .lkpPc(lkpPc),
    .predTaken(predTaken), .predLocal(predLocal), .predGlobal(predGlobal),
    .lkpLocalHist(lkpLocalHist), .lkpGlobalHist(lkpGlobalHist),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updLocalPred(updLocalPred), .updGlobalPred(updGlobalPred),
    .updLocalHist(updLocalHist), .updGlobalHist(updGlobalHist)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst_n = 1'b0; updValid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the next falling edge with the update applied
  task automatic doUpd(input logic [9:0] pc, input logic taken, input logic lp,
                       input logic gp, input logic [9:0] lh, input logic [11:0] gh);
    updPc = pc; updTaken = taken; updLocalPred = lp; updGlobalPred = gp;
    updLocalHist = lh; updGlobalHist = gh; updValid = 1'b1;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic look(input logic [9:0] pc);
    lkpPc = pc;
    #1;
  endtask

  // Twelve not-taken updates on unrelated entries bring the global history back to zero
  task automatic flushGhr();
    for (int i = 0; i < 12; i++) doUpd(10'd448, 1'b0, 1'b0, 1'b0, 10'd60, 12'hABC);
  endtask

  task automatic testReset();
    applyReset();
    look(10'd64);
    chk("R1 local hist", lkpLocalHist, 0);
    chk("R1 global hist", lkpGlobalHist, 0);
    chk("R1 local pred", predLocal, 0);
    chk("R1 global pred", predGlobal, 0);
    chk("R1 final pred", predTaken, 0);
  endtask

  task automatic testHistories();
    applyReset();
    doUpd(10'd64, 1'b1, 1'b0, 1'b0, 10'd5, 12'd7);
    doUpd(10'd64, 1'b0, 1'b0, 1'b0, 10'd5, 12'd7);
    doUpd(10'd64, 1'b1, 1'b0, 1'b0, 10'd5, 12'd7);
    doUpd(10'd64, 1'b1, 1'b0, 1'b0, 10'd5, 12'd7);
    look(10'd64);
    chk("R4 global shift order", lkpGlobalHist, 12'hB);
    chk("R2 local shift order", lkpLocalHist, 10'hB);
    look(10'd65);
    chk("R2 neighbour entry untouched", lkpLocalHist, 0);
    // R11: update fields busy but valid low
    updPc = 10'd64; updTaken = 1'b1; updLocalHist = 10'd5; updGlobalHist = 12'd7;
    repeat (2) @(negedge clk);
    look(10'd64);
    chk("R11 global hist holds", lkpGlobalHist, 12'hB);
    chk("R11 local hist holds", lkpLocalHist, 10'hB);
    for (int i = 0; i < 12; i++) doUpd(10'd100, 1'b1, 1'b0, 1'b0, 10'd5, 12'd7);
    doUpd(10'd100, 1'b0, 1'b0, 1'b0, 10'd5, 12'd7);
    look(10'd100);
    chk("R4 oldest bit dropped", lkpGlobalHist, 12'hFFE);
    chk("R2 local width 10", lkpLocalHist, 10'h3FE);
  endtask

  task automatic testLocalCounter();
    applyReset();
    // lookup address 16 keeps history 0, so it reads local counter 0
    doUpd(10'd192, 1'b1, 1'b0, 1'b0, 10'd0, 12'd100);
    look(10'd16);
    chk("R3 local counter 2 predicts taken", predLocal, 1);
    chk("R7 chooser weak local selects local", predTaken, 1);
    doUpd(10'd192, 1'b1, 1'b0, 1'b0, 10'd0, 12'd100);
    doUpd(10'd192, 1'b1, 1'b0, 1'b0, 10'd0, 12'd100);
    look(10'd16);
    chk("R6 saturates at 3", predLocal, 1);
    doUpd(10'd192, 1'b0, 1'b0, 1'b0, 10'd0, 12'd100);
    look(10'd16);
    chk("R6 3 minus 1 still taken", predLocal, 1);
    doUpd(10'd192, 1'b0, 1'b0, 1'b0, 10'd0, 12'd100);
    look(10'd16);
    chk("R6 value 1 predicts not taken", predLocal, 0);
    doUpd(10'd192, 1'b0, 1'b0, 1'b0, 10'd0, 12'd100);
    doUpd(10'd192, 1'b0, 1'b0, 1'b0, 10'd0, 12'd100);
    doUpd(10'd192, 1'b1, 1'b0, 1'b0, 10'd0, 12'd100);
    doUpd(10'd192, 1'b1, 1'b0, 1'b0, 10'd0, 12'd100);
    look(10'd16);
    chk("R6 saturates at 0", predLocal, 1);
  endtask

  task automatic testGlobalChooser();
    applyReset();
    // global right, local wrong: global counter 0 and chooser 0 climb to 3
    doUpd(10'd320, 1'b1, 1'b0, 1'b1, 10'd50, 12'd0);
    doUpd(10'd320, 1'b1, 1'b0, 1'b1, 10'd50, 12'd0);
    flushGhr();
    look(10'd16);
    chk("R9 history back to zero", lkpGlobalHist, 0);
    chk("R5 R9 global counter at saved index", predGlobal, 1);
    chk("R3 local counter 0 untouched", predLocal, 0);
    chk("R8 R7 chooser moved to global", predTaken, 1);
    // local right: chooser 3 -> 2, still global
    doUpd(10'd384, 1'b1, 1'b1, 1'b0, 10'd200, 12'd0);
    flushGhr();
    look(10'd16);
    chk("R8 chooser 2 still global", predTaken, 1);
    // components agree (both wrong): chooser must hold at 2
    doUpd(10'd384, 1'b1, 1'b0, 1'b0, 10'd200, 12'd0);
    flushGhr();
    look(10'd16);
    chk("R8 agreement leaves chooser", predTaken, 1);
    // local right again: chooser 2 -> 1, local selected
    doUpd(10'd384, 1'b1, 1'b1, 1'b0, 10'd200, 12'd0);
    flushGhr();
    look(10'd16);
    chk("R8 chooser moved to local", predTaken, 0);
    chk("R7 global still predicts taken", predGlobal, 1);
  endtask

  task automatic testSameCycle();
    applyReset();
    lkpPc = 10'd16;
    updPc = 10'd16; updTaken = 1'b1; updLocalPred = 1'b0; updGlobalPred = 1'b0;
    updLocalHist = 10'd0; updGlobalHist = 12'd0; updValid = 1'b1;
    #1;
    chk("R10 local hist pre-update", lkpLocalHist, 0);
    chk("R10 global hist pre-update", lkpGlobalHist, 0);
    chk("R10 local pred pre-update", predLocal, 0);
    @(negedge clk);
    updValid = 1'b0;
    #1;
    chk("R10 local hist after edge", lkpLocalHist, 1);
    chk("R10 global hist after edge", lkpGlobalHist, 1);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    testReset();
    testHistories();
    testLocalCounter();
    testGlobalChooser();
    testSameCycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule